// File: doc/BRIEF.md
# Lookup Reciprocal Divider

This block computes a signed integer quotient in one pass. There is no subtract-and-shift loop. The divisor magnitude goes through a leading-one detector and is aligned into a 10-bit mantissa between 512 and 1023. The position of its leading one is kept as a shift amount. The lower mantissa bits select an entry in a reciprocal table. The dividend magnitude is multiplied by that reciprocal, and the product is shifted right by an amount set by the recorded leading-one position. The sign is then restored from the operand signs, so the result is truncated toward zero.

A caller presents both operands with `in_valid` raised. One clock later the quotient appears, together with `out_valid`, and stays registered until the next valid request. A zero divisor raises a flag and gives a saturated quotient. The one input that overflows the signed result range also saturates. The block is meant to sit inside a ratio-computing element of a larger datapath, where a small bounded error is acceptable and a fixed latency matters more.

Top module: `lut_divider`

## Requirements
- R1: While `rst` is high, `out_valid`, `quotient` and `div_by_zero` are all zero on the following clock edge.
- R2: `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high, so every request has a latency of one clock.
- R3: For a nonzero divisor, when the result is not saturated, `quotient` differs from the exact quotient truncated toward zero by at most 1.
- R4: For a nonzero divisor, `quotient` is never positive when the operands' sign bits (bit 15) differ, and never negative when they match.
- R5: When the divisor magnitude is a power of two, `quotient` equals the exact quotient truncated toward zero, with no error.
- R6: A zero divisor sets `div_by_zero` to 1 and forces `quotient` to 32767 (0x7FFF) if the dividend is zero or positive, and to -32768 (0x8000) if the dividend is negative. For a nonzero divisor `div_by_zero` is 0.
- R7: The dividend -32768 divided by -1 gives 32767, with `div_by_zero` at 0.
- R8: While `in_valid` is low, `quotient` and `div_by_zero` keep their values whatever the operand inputs do.
- R9: A zero dividend with a nonzero divisor gives a quotient of exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are presented this cycle |
| dividend | input | 16 | Signed two's-complement dividend |
| divisor | input | 16 | Signed two's-complement divisor |
| out_valid | output | 1 | Quotient registered from the previous cycle's request |
| quotient | output | 16 | Signed quotient, truncated toward zero, saturated on overflow |
| div_by_zero | output | 1 | Last accepted request had a zero divisor |

## Verification
The bench works through the following corner cases. Each entry names the case and what a faulty design would produce.
- Divisors of 1 and 3. These give the largest quotients. A reciprocal table that is too coarse would miss the exact value by several units here.
- Power-of-two divisors and the most negative dividend. A wrong shift offset gives a quotient off by a factor of two. Wrong handling of the magnitude of -32768 gives a sign flip.
- Mixed-sign operands, checked against truncation toward zero. A design that floors instead of truncating returns a value one too negative.
- A zero divisor with dividends of each sign, and the single overflowing operand pair. If saturation or the flag were missing, these would produce an arbitrary quotient or a wrapped -32768.
- Back-to-back requests followed by idle cycles with changing operands. A design that does not gate its register on `in_valid` would overwrite its held result during the idle cycles.

// File: rtl/lut_div_pkg.sv
package lut_div_pkg;

    // Rounded reciprocal of mantissa m, scaled by 2^scale_exp.
    function automatic longint rcp_entry(input longint m, input int scale_exp);
        longint twice_num;
        twice_num = longint'(1) <<< (scale_exp + 1);
        return (twice_num / m + 1) / 2;
    endfunction

endpackage

// File: rtl/lut_div_norm.sv
module lut_div_norm #(
    parameter int OP_W   = 16,
    parameter int MANT_W = 10,
    localparam int LD_W  = $clog2(OP_W)
) (
    input  logic [OP_W-1:0]   mag,
    output logic [MANT_W-1:0] mant,
    output logic [LD_W-1:0]   lead,
    output logic              is_zero
);

    logic [OP_W-1:0] aligned;

    // Leading-one detector: the highest set bit wins.
    always_comb begin
        lead = '0;
        for (int i = 0; i < OP_W; i++) begin
            if (mag[i]) lead = LD_W'(i);
        end
    end

    // Move the leading one up to the top bit, then keep the upper MANT_W bits.
    always_comb begin
        aligned = mag << (LD_W'(OP_W - 1) - lead);
        mant    = aligned[OP_W-1 -: MANT_W];
        is_zero = (mag == '0);
    end

endmodule

// File: rtl/lut_div_rcp_rom.sv
module lut_div_rcp_rom
    import lut_div_pkg::*;
#(
    parameter int MANT_W = 10,
    parameter int RCP_W  = 18,
    localparam int IDX_W = MANT_W - 1,
    localparam int DEPTH = 1 << IDX_W,
    localparam int SCALE = RCP_W + MANT_W - 2
) (
    input  logic [IDX_W-1:0] idx,
    output logic [RCP_W-1:0] rcp
);

    logic [RCP_W-1:0] table_q [DEPTH];

    // Entry g holds the reciprocal of mantissa (DEPTH + g), whose top bit is implied.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_q[g] = RCP_W'(rcp_entry(longint'(DEPTH + g), SCALE));
    end

    assign rcp = table_q[idx];

endmodule

// File: rtl/lut_div_scale.sv
module lut_div_scale #(
    parameter int OP_W  = 16,
    parameter int RCP_W = 18,
    localparam int LD_W = $clog2(OP_W),
    localparam int P_W  = OP_W + RCP_W,
    localparam int SH_W = $clog2(P_W)
) (
    input  logic [OP_W-1:0]  mag_a,
    input  logic [RCP_W-1:0] rcp,
    input  logic [LD_W-1:0]  lead,
    output logic [OP_W:0]    mag_q
);

    logic [P_W-1:0]  prod;
    logic [P_W-1:0]  shifted;
    logic [SH_W-1:0] sh_amt;

    // The reciprocal carries 2^(RCP_W-1) of scale for a divisor whose leading one is at bit 0.
    always_comb begin
        prod    = P_W'(mag_a) * P_W'(rcp);
        sh_amt  = SH_W'(RCP_W - 1) + SH_W'(lead);
        shifted = prod >> sh_amt;
        mag_q   = shifted[OP_W:0];
    end

endmodule

// File: rtl/lut_divider.sv
module lut_divider #(
    parameter int OP_W   = 16,
    parameter int MANT_W = 10,
    parameter int RCP_W  = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] dividend,
    input  logic [OP_W-1:0] divisor,
    output logic            out_valid,
    output logic [OP_W-1:0] quotient,
    output logic            div_by_zero
);

    localparam int LD_W  = $clog2(OP_W);
    localparam int IDX_W = MANT_W - 1;
    localparam logic [OP_W-1:0] POS_MAX = {1'b0, {(OP_W-1){1'b1}}};
    localparam logic [OP_W-1:0] NEG_MIN = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [OP_W:0]   MAG_POS = {2'b00, {(OP_W-1){1'b1}}};
    localparam logic [OP_W:0]   MAG_NEG = {2'b01, {(OP_W-1){1'b0}}};

    logic              a_neg, b_neg;
    logic [OP_W-1:0]   a_mag, b_mag;
    logic [MANT_W-1:0] b_mant;
    logic [LD_W-1:0]   b_lead;
    logic              b_zero;
    logic [RCP_W-1:0]  rcp;
    logic [OP_W:0]     q_mag;
    logic [OP_W:0]     q_mag_neg;
    logic [OP_W-1:0]   q_next;
    logic              dz_next;

    // Sign-magnitude split of both operands.
    always_comb begin
        a_neg = dividend[OP_W-1];
        b_neg = divisor[OP_W-1];
        a_mag = a_neg ? (~dividend + 1'b1) : dividend;
        b_mag = b_neg ? (~divisor + 1'b1) : divisor;
    end

    lut_div_norm #(.OP_W(OP_W), .MANT_W(MANT_W)) u_norm (
        .mag     (b_mag),
        .mant    (b_mant),
        .lead    (b_lead),
        .is_zero (b_zero)
    );

    lut_div_rcp_rom #(.MANT_W(MANT_W), .RCP_W(RCP_W)) u_rom (
        .idx (b_mant[IDX_W-1:0]),
        .rcp (rcp)
    );

    lut_div_scale #(.OP_W(OP_W), .RCP_W(RCP_W)) u_scale (
        .mag_a (a_mag),
        .rcp   (rcp),
        .lead  (b_lead),
        .mag_q (q_mag)
    );

    // Result selection: zero-divisor saturation, sign restore, range clamp.
    always_comb begin
        q_mag_neg = ~q_mag + 1'b1;
        dz_next   = b_zero;
        if (b_zero) begin
            q_next = a_neg ? NEG_MIN : POS_MAX;
        end else if (a_neg ^ b_neg) begin
            q_next = (q_mag > MAG_NEG) ? NEG_MIN : q_mag_neg[OP_W-1:0];
        end else begin
            q_next = (q_mag > MAG_POS) ? POS_MAX : q_mag[OP_W-1:0];
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            quotient    <= '0;
            div_by_zero <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                quotient    <= q_next;
                div_by_zero <= dz_next;
            end
        end
    end

endmodule

// File: rtl/lut_divider_chk.sv
module lut_divider_chk #(
    parameter int OP_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [OP_W-1:0] dividend,
    input logic [OP_W-1:0] divisor,
    input logic            out_valid,
    input logic [OP_W-1:0] quotient,
    input logic            div_by_zero
);

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(quotient) && $stable(div_by_zero)));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && divisor == '0) |=> div_by_zero);

    // R6
    no_false_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && divisor != '0) |=> !div_by_zero);

    // R9
    zero_dividend_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dividend == '0 && divisor != '0) |=> (quotient == '0));

    // R4
    mixed_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && divisor != '0 && (dividend[OP_W-1] ^ divisor[OP_W-1]))
        |=> ($signed(quotient) <= 0));

    // R4
    same_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && divisor != '0 && !(dividend[OP_W-1] ^ divisor[OP_W-1]))
        |=> ($signed(quotient) >= 0));

endmodule

bind lut_divider lut_divider_chk #(.OP_W(OP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .dividend    (dividend),
    .divisor     (divisor),
    .out_valid   (out_valid),
    .quotient    (quotient),
    .div_by_zero (div_by_zero)
);

// File: tb/lut_divider_tb.sv
module lut_divider_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;
    localparam int NRAND = 3000;

    typedef struct packed {
        logic signed [15:0] a;
        logic signed [15:0] b;
        logic signed [15:0] e;
        logic [1:0]         tol;
        logic               dz;
        logic [3:0]         req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'sd100,    16'sd7,     16'sd14,     2'd1, 1'b0, 4'd3},
        '{16'sd1000,   -16'sd3,    -16'sd333,   2'd1, 1'b0, 4'd3},
        '{-16'sd32768, 16'sd2,     -16'sd16384, 2'd0, 1'b0, 4'd5},
        '{16'sd12345,  16'sd1,     16'sd12345,  2'd0, 1'b0, 4'd5},
        '{-16'sd12345, -16'sd1,    16'sd12345,  2'd0, 1'b0, 4'd5},
        '{16'sd0,      16'sd5,     16'sd0,      2'd0, 1'b0, 4'd9},
        '{16'sd32767,  16'sd32767, 16'sd1,      2'd1, 1'b0, 4'd3},
        '{16'sd30000,  16'sd1024,  16'sd29,     2'd0, 1'b0, 4'd5},
        '{-16'sd30000, 16'sd1024,  -16'sd29,    2'd0, 1'b0, 4'd5},
        '{-16'sd32768, -16'sd1,    16'sd32767,  2'd0, 1'b0, 4'd7},
        '{16'sd5,      16'sd0,     16'sd32767,  2'd0, 1'b1, 4'd6},
        '{-16'sd5,     16'sd0,     -16'sd32768, 2'd0, 1'b1, 4'd6},
        '{16'sd0,      16'sd0,     16'sd32767,  2'd0, 1'b1, 4'd6},
        '{16'sd32767,  16'sd3,     16'sd10922,  2'd1, 1'b0, 4'd3},
        '{-16'sd1,     16'sd32767, 16'sd0,      2'd1, 1'b0, 4'd3},
        '{-16'sd32768, 16'sd1,     -16'sd32768, 2'd0, 1'b0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        out_valid;
    logic [15:0] quotient;
    logic        div_by_zero;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_divider u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .dividend    (dividend),
        .divisor     (divisor),
        .out_valid   (out_valid),
        .quotient    (quotient),
        .div_by_zero (div_by_zero)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd9:    return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one request, then sample at the following falling edge.
    task automatic run_one(input logic signed [15:0] a, input logic signed [15:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        dividend = a;
        divisor  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        int held_q;
        int held_dz;
        int diff;
        int exp_q;
        logic signed [15:0] ra;
        logic signed [15:0] rb;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(quotient == 16'd0, "R1", int'(quotient), 0);
        check(div_by_zero == 1'b0, "R1", int'(div_by_zero), 0);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i].a, VECS[i].b);
            check(out_valid == 1'b1, "R2", int'(out_valid), 1);
            diff = int'($signed(quotient)) - int'(VECS[i].e);
            if (diff < 0) diff = -diff;
            check(diff <= int'(VECS[i].tol), req_name(VECS[i].req),
                  int'($signed(quotient)), int'(VECS[i].e));
            check(div_by_zero == VECS[i].dz, "R6", int'(div_by_zero), int'(VECS[i].dz));
        end

        // R8: result and flag held while idle and operands change
        run_one(16'sd777, 16'sd7);
        held_q = int'($signed(quotient));
        for (int k = 0; k < 3; k++) begin
            dividend = 16'(k * 911 + 3);
            divisor  = 16'(k);
            @(negedge clk);
            check(out_valid == 1'b0, "R2", int'(out_valid), 0);
            check(int'($signed(quotient)) == held_q, "R8", int'($signed(quotient)), held_q);
        end
        run_one(16'sd3, 16'sd0);
        held_dz = int'(div_by_zero);
        check(held_dz == 1, "R6", held_dz, 1);
        dividend = 16'sd40;
        divisor  = 16'sd9;
        repeat (2) @(negedge clk);
        check(int'(div_by_zero) == held_dz, "R8", int'(div_by_zero), held_dz);
        check(quotient == 16'h7FFF, "R8", int'($signed(quotient)), 32767);

        // R2: back-to-back requests, each checked one clock later
        @(negedge clk);
        in_valid = 1'b1;
        dividend = 16'sd900;
        divisor  = 16'sd4;
        @(negedge clk);
        check(out_valid == 1'b1, "R2", int'(out_valid), 1);
        check($signed(quotient) == 16'sd225, "R5", int'($signed(quotient)), 225);
        dividend = -16'sd900;
        divisor  = 16'sd8;
        @(negedge clk);
        check(out_valid == 1'b1, "R2", int'(out_valid), 1);
        check($signed(quotient) == -16'sd112, "R5", int'($signed(quotient)), -112);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);

        // R3 and R4: random operands
        for (int n = 0; n < NRAND; n++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (n % 4 == 1) rb = 16'($signed(rb) >>> 10);
            if (rb == 16'sd0) rb = 16'sd1;
            if (ra == -16'sd32768 && rb == -16'sd1) rb = 16'sd1;
            run_one(ra, rb);
            exp_q = int'(ra) / int'(rb);
            diff = int'($signed(quotient)) - exp_q;
            if (diff < 0) diff = -diff;
            if (exp_q == 32768) diff = 0;
            check(diff <= 1, "R3", int'($signed(quotient)), exp_q);
            if ((ra < 0) != (rb < 0))
                check($signed(quotient) <= 0, "R4", int'($signed(quotient)), exp_q);
            else
                check($signed(quotient) >= 0, "R4", int'($signed(quotient)), exp_q);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule